// File: doc/BRIEF.md
# Lockable Over-Temperature Control Registers

This block is the register front end of an on-die temperature monitor. Boot firmware uses a synchronous register port to program three things: a critical temperature threshold, a calibration slope that turns raw sensor counts into degrees Celsius, and an enable for the hardware shutdown response. It then sets a lock bit that can be set only once. From that point the threshold, the slope and the shutdown enable can no longer be written. Software therefore cannot defeat the protection by retuning the conversion or by switching the response off.

Each valid raw sample is scaled by the slope and saturated to eight bits. The result appears in a current-temperature register that can only be read. When the converted temperature is above the threshold while shutdown is enabled, the block raises a shutdown request. The request stays high until reset. Both the analog sensor and the power-down sequencing sit outside this block.

Top module: `thermal_guard_regs`

## Requirements
- R1: After reset, offset 0x00 reads 125, 0x04 reads 25, 0x08 reads 0, 0x0C reads 0, 0x10 reads 0, and shutdown_req is 0.
- R2: While unlocked, a write to offset 0x00 loads the threshold from wr_data[7:0]. Bits [31:8] of that register always read 0.
- R3: While unlocked, a write to offset 0x04 loads all 32 bits of the calibration slope.
- R4: While unlocked, a write to offset 0x0C loads the shutdown enable from wr_data[1]. Every other bit of that register reads 0.
- R5: Writing 1 to bit 0 of offset 0x08 sets the lock, and the register reads 1. Writing 0 leaves the lock unchanged. Only reset clears it.
- R6: While the lock is set, writes to 0x00, 0x04 and 0x0C are ignored, and those registers keep their values.
- R7: On the clock edge that samples raw_valid high, offset 0x10 is loaded with min(255, (raw_sample × slope) >> 4). It keeps its value on every other cycle and ignores writes.
- R8: If the current temperature is strictly greater than the threshold while the enable is 1, shutdown_req is high from the next clock edge.
- R9: Once high, shutdown_req stays high until reset, even after the temperature falls or the condition goes away.
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 (including unaligned ones) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| raw_valid | input | 1 | Raw sample strobe |
| raw_sample | input | 12 | Raw sensor count |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
The hardest case to reach is an attempted bypass after locking. The configuration has been frozen with the response disabled or the temperature below the threshold, and software then tries to raise the slope or enable shutdown so that a trip would follow. A directed sequence locks the block with a safe configuration, issues those writes, and feeds samples that would trip only if a write had taken effect. Random operations with a fixed seed then lock at varying points and interleave writes, samples and occasional resets. This covers ordering cases, such as a trip that happens before the lock against one that happens after it.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int TEMP_W    = 8;
    localparam int SLOPE_W   = 32;
    localparam int RAW_W     = 12;
    localparam int FRAC_BITS = 4;

    localparam logic [ADDR_W-1:0] OFS_LIMIT = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_SLOPE = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RESP  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_TEMP  = 5'h10;

    localparam int EN_BIT = 1;

    localparam logic [TEMP_W-1:0]  LIMIT_RST = 8'd125;
    localparam logic [SLOPE_W-1:0] SLOPE_RST = 32'd25;

    typedef struct packed {
        logic [TEMP_W-1:0]  limit;
        logic [SLOPE_W-1:0] slope;
        logic               lock;
        logic               resp_en;
    } cfg_t;
endpackage

// File: rtl/tg_cfg_regs.sv
module tg_cfg_regs
    import thermal_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == OFS_LOCK) begin
                cfg_d.lock = cfg_q.lock | wr_data[0];
            end else if (!cfg_q.lock) begin
                unique case (addr)
                    OFS_LIMIT: cfg_d.limit   = wr_data[TEMP_W-1:0];
                    OFS_SLOPE: cfg_d.slope   = wr_data[SLOPE_W-1:0];
                    OFS_RESP:  cfg_d.resp_en = wr_data[EN_BIT];
                    default:   cfg_d = cfg_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.limit   <= LIMIT_RST;
            cfg_q.slope   <= SLOPE_RST;
            cfg_q.lock    <= 1'b0;
            cfg_q.resp_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/tg_convert.sv
module tg_convert
    import thermal_guard_pkg::*;
#(
    parameter int RW = RAW_W,
    parameter int SW = SLOPE_W,
    parameter int TW = TEMP_W,
    parameter int FB = FRAC_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_valid,
    input  logic [RW-1:0] raw_sample,
    input  logic [SW-1:0] slope,
    output logic [TW-1:0] temp
);
    localparam int PW = RW + SW;

    logic [PW-1:0] prod, scaled;
    logic          over;
    logic [TW-1:0] temp_d, temp_q;

    always_comb begin
        prod   = PW'(raw_sample) * PW'(slope);
        scaled = prod >> FB;
        over   = |scaled[PW-1:TW];
        temp_d = temp_q;
        if (raw_valid) begin
            temp_d = over ? {TW{1'b1}} : scaled[TW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) temp_q <= '0;
        else        temp_q <= temp_d;
    end

    assign temp = temp_q;
endmodule

// File: rtl/tg_trip.sv
module tg_trip
    import thermal_guard_pkg::*;
#(
    parameter int TW = TEMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] limit,
    input  logic          resp_en,
    output logic          req
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q | (resp_en && (temp > limit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;
endmodule

// File: rtl/thermal_guard_regs.sv
module thermal_guard_regs
    import thermal_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_sample,
    output logic              shutdown_req
);
    cfg_t              cfg;
    logic [TEMP_W-1:0] cur_temp;

    tg_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    tg_convert u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_sample (raw_sample),
        .slope      (cfg.slope),
        .temp       (cur_temp)
    );

    tg_trip u_trip (
        .clk     (clk),
        .rst_n   (rst_n),
        .temp    (cur_temp),
        .limit   (cfg.limit),
        .resp_en (cfg.resp_en),
        .req     (shutdown_req)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFS_LIMIT: rd_data[TEMP_W-1:0]  = cfg.limit;
            OFS_SLOPE: rd_data[SLOPE_W-1:0] = cfg.slope;
            OFS_LOCK:  rd_data[0]           = cfg.lock;
            OFS_RESP:  rd_data[EN_BIT]      = cfg.resp_en;
            OFS_TEMP:  rd_data[TEMP_W-1:0]  = cur_temp;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk
    import thermal_guard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              raw_valid,
    input logic              shutdown_req,
    input cfg_t              cfg,
    input logic [TEMP_W-1:0] cur_temp
);
    logic mapped;
    assign mapped = (addr == OFS_LIMIT) || (addr == OFS_SLOPE) || (addr == OFS_LOCK)
                 || (addr == OFS_RESP)  || (addr == OFS_TEMP);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> cfg.lock);

    // R6
    locked_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> $stable(cfg.limit));

    // R6
    locked_slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> $stable(cfg.slope));

    // R6
    locked_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> $stable(cfg.resp_en));

    // R7
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> $stable(cur_temp));

    // R8
    trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.resp_en && (cur_temp > cfg.limit)) |=> shutdown_req);

    // R9
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rd_data == '0));

    // R5
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_LOCK) && wr_data[0]) |=> cfg.lock);
endmodule

bind thermal_guard_regs thermal_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .raw_valid    (raw_valid),
    .shutdown_req (shutdown_req),
    .cfg          (cfg),
    .cur_temp     (cur_temp)
);

// File: tb/sim_thermal_guard_regs.sv
`timescale 1ns/1ps
module sim_thermal_guard_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        raw_valid = 1'b0;
    logic [11:0] raw_sample = '0;
    logic        shutdown_req;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0]  m_lim;
    logic [31:0] m_slope;
    logic        m_lock, m_en, m_sd;
    logic [7:0]  m_temp;

    always #4 clk = ~clk;

    thermal_guard_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .raw_valid(raw_valid), .raw_sample(raw_sample),
        .shutdown_req(shutdown_req)
    );

    function automatic logic [7:0] conv(input logic [11:0] r, input logic [31:0] s);
        logic [43:0] p;
        p = ({32'd0, r} * {12'd0, s}) >> 4;
        return (p > 44'd255) ? 8'd255 : p[7:0];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00:   return {24'd0, m_lim};
            5'h04:   return m_slope;
            5'h08:   return {31'd0, m_lock};
            5'h0C:   return {30'd0, m_en, 1'b0};
            5'h10:   return {24'd0, m_temp};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00:   return "R2/R6";
            5'h04:   return "R3/R6";
            5'h08:   return "R5";
            5'h0C:   return "R4/R6";
            5'h10:   return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_lim = 8'd125; m_slope = 32'd25; m_lock = 0; m_en = 0; m_sd = 0; m_temp = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; raw_valid = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one clock: drive at negedge, model advances at posedge
    task automatic step(input bit w, input logic [4:0] a, input logic [31:0] d,
                        input bit rv, input logic [11:0] r);
        logic nsd;
        wr_en = w; addr = a; wr_data = d; raw_valid = rv; raw_sample = r;
        @(posedge clk);
        nsd = m_sd | (m_en && (m_temp > m_lim));
        if (rv) m_temp = conv(r, m_slope);
        if (w) begin
            if (a == 5'h08) m_lock = m_lock | d[0];
            else if (!m_lock) begin
                if (a == 5'h00) m_lim = d[7:0];
                if (a == 5'h04) m_slope = d;
                if (a == 5'h0C) m_en = d[1];
            end
        end
        m_sd = nsd;
        @(negedge clk);
        wr_en = 0; raw_valid = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1, a, d, 0, '0);
    endtask

    task automatic sample(input logic [11:0] r);
        step(0, 5'h00, '0, 1, r);
    endtask

    task automatic chk_rd(input logic [4:0] a, input string tag);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp_rd(a)) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp_rd(a));
        end
    endtask

    task automatic chk_sd(input string tag);
        checks++;
        if (shutdown_req !== m_sd) begin
            fails++;
            $display("FAIL %s shutdown_req actual=%b expected=%b", tag, shutdown_req, m_sd);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        model_reset();
        do_reset();

        // R1 reset values
        chk_rd(5'h00, "R1"); chk_rd(5'h04, "R1"); chk_rd(5'h08, "R1");
        chk_rd(5'h0C, "R1"); chk_rd(5'h10, "R1"); chk_sd("R1");

        // R2 upper bits dropped
        wr(5'h00, 32'hFFFF_FF40); chk_rd(5'h00, "R2");
        // R3 full width
        wr(5'h04, 32'hDEAD_BEEF); chk_rd(5'h04, "R3");
        // R4 only bit 1 kept
        wr(5'h0C, 32'hFFFF_FFFD); chk_rd(5'h0C, "R4");
        wr(5'h0C, 32'h0000_0002); chk_rd(5'h0C, "R4");
        wr(5'h0C, 32'h0); chk_rd(5'h0C, "R4");
        // R10 unmapped and unaligned
        chk_rd(5'h01, "R10"); chk_rd(5'h14, "R10"); chk_rd(5'h1C, "R10"); chk_rd(5'h0E, "R10");

        // R7 conversion, write ignored, saturation
        wr(5'h04, 32'd16); sample(12'd100); chk_rd(5'h10, "R7");
        wr(5'h10, 32'hFF); chk_rd(5'h10, "R7");
        wr(5'h04, 32'hFFFF_FFFF); sample(12'hFFF); chk_rd(5'h10, "R7");
        wr(5'h04, 32'd3); sample(12'd37); chk_rd(5'h10, "R7");

        // R8 trip and R9 stickiness
        wr(5'h00, 32'd50); wr(5'h04, 32'd16); sample(12'd50); chk_rd(5'h10, "R8");
        wr(5'h0C, 32'h2); step(0, 5'h00, '0, 0, '0); chk_sd("R8");
        sample(12'd51); chk_sd("R8");
        step(0, 5'h00, '0, 0, '0); chk_sd("R8");
        sample(12'd10); step(0, 5'h00, '0, 0, '0); chk_sd("R9");
        wr(5'h0C, 32'h0); step(0, 5'h00, '0, 0, '0); chk_sd("R9");

        // R5 / R6 lock, then bypass attempts
        do_reset();
        wr(5'h08, 32'h0); chk_rd(5'h08, "R5");
        wr(5'h00, 32'd200); wr(5'h04, 32'd16);
        wr(5'h08, 32'h1); chk_rd(5'h08, "R5");
        wr(5'h08, 32'h0); chk_rd(5'h08, "R5");
        wr(5'h00, 32'd5);  chk_rd(5'h00, "R6");
        wr(5'h04, 32'd900); chk_rd(5'h04, "R6");
        wr(5'h0C, 32'h2);  chk_rd(5'h0C, "R6");
        sample(12'd4000); step(0, 5'h00, '0, 0, '0); step(0, 5'h00, '0, 0, '0);
        chk_rd(5'h10, "R7"); chk_sd("R6");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [4:0] a;
            op = $urandom_range(0, 99);
            a = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 1) == 1) a = {a[4:2], 2'b00};
            if (op < 2) begin
                do_reset();
            end else if (op < 50) begin
                logic [31:0] d;
                d = $urandom();
                if (a == 5'h04) d = d & 32'h7F;
                if (a == 5'h00) d = d & 32'hFF;
                if (a == 5'h08 && $urandom_range(0, 9) != 0) d = d & 32'hFFFF_FFFE;
                wr(a, d);
            end else if (op < 85) begin
                sample(12'($urandom_range(0, 4095)));
            end else begin
                step(0, a, '0, 0, '0);
            end
            chk_rd(a, tag_of(a));
            chk_sd("R8/R9");
        end

        finish_run();
    end
endmodule